// File: doc/BRIEF.md
# Floating-Point Rounding Unit

This block sits at the end of a floating-point datapath. It takes a result that has not been rounded yet and turns it into a binary floating-point word, by default single precision. The unrounded value comes in as a sign, a biased exponent, a significand with its leading bit written out, and a few lower-order bits beyond the kept precision. The first of those bits is the guard bit. The rest fold into a sticky bit. One of four rounding directions is chosen per operation.

Rounding can carry out of the top of the significand. When it does, the result is renormalised and the exponent goes up by one. An exponent field of zero marks a subnormal operand. A subnormal that rounds up into the leading bit becomes the smallest normal number. A result whose exponent leaves the finite range produces either infinity or the largest finite magnitude, depending on the rounding direction. Two flags report inexactness and overflow. The block is one registered stage with a valid bit travelling next to the data.

Top module: `fp_round_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `out_valid`, `out_word`, `out_inexact` and `out_overflow` all at zero, even if `in_valid` is high.
- R2: `out_valid` equals `in_valid` of the previous cycle. The result appears one edge after the input is taken. On a cycle with `in_valid` low, `out_word` and both flags keep their values.
- R3: Mode code 2'b00 rounds to nearest. If the discarded part is under half an ulp, it is dropped. If it is over half, the magnitude goes up by one ulp. On an exact half (top discarded bit 1, all others 0), the kept significand takes the neighbour whose last bit is 0.
- R4: Mode code 2'b01 truncates the magnitude. For a normal input with an in-range exponent, the output fields equal the input sign, exponent and fraction.
- R5: Mode code 2'b10 rounds toward plus infinity. A positive value with any nonzero discarded bit goes up one ulp in magnitude. A negative value is truncated.
- R6: Mode code 2'b11 rounds toward minus infinity. A negative value with any nonzero discarded bit goes up one ulp in magnitude. A positive value is truncated.
- R7: If rounding up overflows an all-ones significand, the fraction becomes zero and the exponent field goes up by one.
- R8: An input exponent field of 0 marks a subnormal whose explicit leading bit is 0. The output exponent stays 0 unless rounding reaches the leading bit, which gives exponent field 1.
- R9: Overflow is raised when the exponent after rounding is all ones or more; an all-ones input exponent is therefore always an overflow. The result is then infinity (exponent all ones, fraction 0) in modes 2'b00 and in the directed mode matching the sign. In mode 2'b01 and in the directed mode opposite to the sign, the result is the largest finite value (exponent all ones minus one, fraction all ones). No other output has an all-ones exponent.
- R10: `out_inexact` is 1 exactly when any discarded bit is nonzero or overflow is raised.
- R11: `out_word` holds the sign in its MSB, then the exponent field, then the fraction in the low `FRAC_W` bits. The sign always passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input fields hold an operand this cycle |
| in_mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | EXP_W | Biased exponent; 0 marks a subnormal significand |
| in_sig | input | FRAC_W+1 | Significand with explicit leading bit in the MSB |
| in_extra | input | EXTRA_W | Bits below the kept precision; MSB is the guard bit |
| out_valid | output | 1 | Result registers hold a new result |
| out_word | output | 1+EXP_W+FRAC_W | Rounded encoded result |
| out_inexact | output | 1 | Result differs from the unrounded value |
| out_overflow | output | 1 | Exponent left the finite range |

## Verification
The bench builds the unit with a 4-bit exponent, a 3-bit fraction and 3 extra bits. That makes the whole input space small enough to sweep completely: all sixteen exponent fields, every significand allowed for each, every guard/sticky pattern, both signs and all four modes. Every tie, every carry from an all-ones significand, every subnormal that does or does not reach the normal range, and every overflow in each direction is therefore reached. Each output is compared against an integer model of the rounded magnitude.

// File: rtl/fpr_pkg.sv
// Shared types for the rounding unit.
// Assumes: the two-bit mode code is decoded only through this enum.
package fpr_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_ZERO   = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_NEG    = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/fpr_round_decide.sv
// Decides whether the kept significand is bumped by one ulp and forms the
// incremented significand, one bit wider so a carry-out stays visible.
// Assumes: the MSB of extra is the guard bit; the other extra bits are sticky.
module fpr_round_decide
    import fpr_pkg::*;
#(
    parameter int FRAC_W  = 23,
    parameter int EXTRA_W = 3
) (
    input  logic              sign,
    input  rnd_mode_e         mode,
    input  logic [FRAC_W:0]   sig,
    input  logic [EXTRA_W-1:0] extra,
    output logic              discard_nz,
    output logic [FRAC_W+1:0] rounded
);

    logic guard_bit;
    logic sticky_bit;
    logic bump;

    assign guard_bit  = extra[EXTRA_W-1];
    assign discard_nz = |extra;

    // With a single extra bit there is nothing below the guard.
    generate
        if (EXTRA_W > 1) begin : g_sticky
            assign sticky_bit = |extra[EXTRA_W-2:0];
        end else begin : g_no_sticky
            assign sticky_bit = 1'b0;
        end
    endgenerate

    // Increment decision per rounding direction.
    always_comb begin
        unique case (mode)
            RND_NEAR_EVEN: bump = guard_bit & (sticky_bit | sig[0]);
            RND_TO_ZERO:   bump = 1'b0;
            RND_TO_POS:    bump = discard_nz & ~sign;
            RND_TO_NEG:    bump = discard_nz & sign;
            default:       bump = 1'b0;
        endcase
    end

    // Apply the increment; bit FRAC_W+1 is the carry-out.
    assign rounded = {1'b0, sig} + {{(FRAC_W + 1){1'b0}}, bump};

endmodule

// File: rtl/fpr_pack.sv
// Renormalises a rounded significand, resolves the exponent, detects
// overflow and packs sign, exponent and fraction into one word.
// Assumes: exp_in of 0 carries a subnormal significand (leading bit 0 or a
// leading bit produced by rounding); exp_in above 0 carries leading bit 1.
module fpr_pack
    import fpr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    sign,
    input  rnd_mode_e               mode,
    input  logic [EXP_W-1:0]        exp_in,
    input  logic [FRAC_W+1:0]       rounded,
    input  logic                    discard_nz,
    output logic [EXP_W+FRAC_W:0]   word,
    output logic                    overflow,
    output logic                    inexact
);

    localparam logic [EXP_W:0]   EXP_LIMIT = {1'b0, {EXP_W{1'b1}}};
    localparam logic [EXP_W-1:0] EXP_INF   = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_SAT   = {{(EXP_W - 1){1'b1}}, 1'b0};

    logic [EXP_W:0]    exp_eff;
    logic [EXP_W:0]    exp_next;
    logic [FRAC_W-1:0] frac_next;
    logic              saturate;

    // A subnormal sits at the same scale as exponent field 1.
    assign exp_eff = (exp_in == '0) ? {{EXP_W{1'b0}}, 1'b1} : {1'b0, exp_in};

    // Renormalise after a carry, or fall back to the subnormal field.
    always_comb begin
        if (rounded[FRAC_W+1]) begin
            exp_next  = exp_eff + 1'b1;
            frac_next = rounded[FRAC_W:1];
        end else if (rounded[FRAC_W]) begin
            exp_next  = exp_eff;
            frac_next = rounded[FRAC_W-1:0];
        end else begin
            exp_next  = '0;
            frac_next = rounded[FRAC_W-1:0];
        end
    end

    assign overflow = (exp_next >= EXP_LIMIT);
    assign inexact  = discard_nz | overflow;

    // Directions that never move away from zero clamp to the largest finite.
    assign saturate = (mode == RND_TO_ZERO)
                    | ((mode == RND_TO_POS) & sign)
                    | ((mode == RND_TO_NEG) & ~sign);

    // Final encoding.
    always_comb begin
        if (overflow && saturate) begin
            word = {sign, EXP_SAT, {FRAC_W{1'b1}}};
        end else if (overflow) begin
            word = {sign, EXP_INF, {FRAC_W{1'b0}}};
        end else begin
            word = {sign, exp_next[EXP_W-1:0], frac_next};
        end
    end

endmodule

// File: rtl/fp_round_unit.sv
// Rounding stage: rounds an unrounded floating-point value under one of four
// directions and registers the packed word and flags, one cycle of latency.
// Assumes: operands follow the encoding rules given in fpr_pack.
module fp_round_unit
    import fpr_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int EXTRA_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                in_mode,
    input  logic                      in_sign,
    input  logic [EXP_W-1:0]          in_exp,
    input  logic [FRAC_W:0]           in_sig,
    input  logic [EXTRA_W-1:0]        in_extra,
    output logic                      out_valid,
    output logic [EXP_W+FRAC_W:0]     out_word,
    output logic                      out_inexact,
    output logic                      out_overflow
);

    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    rnd_mode_e         mode;
    logic              discard_nz;
    logic [FRAC_W+1:0] rounded;
    logic [WORD_W-1:0] word_c;
    logic              ovf_c;
    logic              inx_c;

    assign mode = rnd_mode_e'(in_mode);

    fpr_round_decide #(
        .FRAC_W  (FRAC_W),
        .EXTRA_W (EXTRA_W)
    ) u_decide (
        .sign       (in_sign),
        .mode       (mode),
        .sig        (in_sig),
        .extra      (in_extra),
        .discard_nz (discard_nz),
        .rounded    (rounded)
    );

    fpr_pack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_pack (
        .sign       (in_sign),
        .mode       (mode),
        .exp_in     (in_exp),
        .rounded    (rounded),
        .discard_nz (discard_nz),
        .word       (word_c),
        .overflow   (ovf_c),
        .inexact    (inx_c)
    );

    // Output register: clear on reset, capture only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_word     <= '0;
            out_inexact  <= 1'b0;
            out_overflow <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word     <= word_c;
                out_inexact  <= inx_c;
                out_overflow <= ovf_c;
            end
        end
    end

endmodule

// File: rtl/fp_round_unit_chk.sv
// Port-level properties of the rounding stage; bound to every instance.
module fp_round_unit_chk #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int EXTRA_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [1:0]            in_mode,
    input logic                  in_sign,
    input logic [EXP_W-1:0]      in_exp,
    input logic [FRAC_W:0]       in_sig,
    input logic [EXTRA_W-1:0]    in_extra,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] out_word,
    input logic                  out_inexact,
    input logic                  out_overflow
);

    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_SAT  = {{(EXP_W - 1){1'b1}}, 1'b0};

    logic [EXP_W-1:0]  o_exp;
    logic [FRAC_W-1:0] o_frac;
    assign o_exp  = out_word[EXP_W+FRAC_W-1:FRAC_W];
    assign o_frac = out_word[FRAC_W-1:0];

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word) && $stable(out_inexact) && $stable(out_overflow));
    // R11
    sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[EXP_W+FRAC_W] == $past(in_sign));
    // R4
    trunc_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01 && in_exp != '0 && in_exp != EXP_ONES)
        |=> out_word == {$past(in_sign), $past(in_exp), $past(in_sig[FRAC_W-1:0])});
    // R9
    ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow)
        |-> ((o_exp == EXP_ONES && o_frac == '0) || (o_exp == EXP_SAT && &o_frac)));
    // R9
    no_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(o_exp == EXP_ONES && o_frac != '0));
    // R10
    ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> out_inexact);
    // R10
    exact_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_extra == '0 && in_exp != EXP_ONES) |=> !out_inexact);

endmodule

bind fp_round_unit fp_round_unit_chk #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .EXTRA_W (EXTRA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_mode      (in_mode),
    .in_sign      (in_sign),
    .in_exp       (in_exp),
    .in_sig       (in_sig),
    .in_extra     (in_extra),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .out_inexact  (out_inexact),
    .out_overflow (out_overflow)
);

// File: tb/fp_round_unit_tb.sv
`timescale 1ns/1ps
module fp_round_unit_tb;

    localparam int EW = 4;
    localparam int FW = 3;
    localparam int XW = 3;
    localparam int WW = 1 + EW + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [FW:0]   in_sig = '0;
    logic [XW-1:0] in_extra = '0;
    logic          out_valid;
    logic [WW-1:0] out_word;
    logic          out_inexact;
    logic          out_overflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fp_round_unit #(.EXP_W(EW), .FRAC_W(FW), .EXTRA_W(XW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_extra(in_extra),
        .out_valid(out_valid), .out_word(out_word),
        .out_inexact(out_inexact), .out_overflow(out_overflow)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp_v, $time);
        end
    endtask

    // Arithmetic model: rounded magnitude, exponent, flags; cls names the requirement.
    task automatic model(input int s, input int m, input int e, input int sg, input int x,
                         output int word, output int inx, output int ovf, output string cls);
        int half, up, q, ee, fe, frac, carry;
        half = 1 << (XW - 1);
        case (m)
            0: up = (x > half || (x == half && (sg % 2) == 1)) ? 1 : 0;
            1: up = 0;
            2: up = (x != 0 && s == 0) ? 1 : 0;
            default: up = (x != 0 && s == 1) ? 1 : 0;
        endcase
        q = sg + up;
        ee = (e == 0) ? 1 : e;
        carry = 0;
        if (q >= (1 << (FW + 1))) begin
            q = q / 2;
            ee = ee + 1;
            carry = 1;
        end
        fe = (q < (1 << FW)) ? 0 : ee;
        frac = q % (1 << FW);
        ovf = (fe >= (1 << EW) - 1) ? 1 : 0;
        inx = (x != 0 || ovf == 1) ? 1 : 0;
        if (ovf == 1) begin
            if (m == 1 || (m == 2 && s == 1) || (m == 3 && s == 0))
                word = (s << (EW + FW)) | (((1 << EW) - 2) << FW) | ((1 << FW) - 1);
            else
                word = (s << (EW + FW)) | (((1 << EW) - 1) << FW);
            cls = "R9";
        end else begin
            word = (s << (EW + FW)) | (fe << FW) | frac;
            if (carry == 1)      cls = "R7";
            else if (e == 0)     cls = "R8";
            else if (m == 0)     cls = "R3";
            else if (m == 1)     cls = "R4";
            else if (m == 2)     cls = "R5";
            else                 cls = "R6";
        end
    endtask

    initial begin
        int w, ix, ov;
        string cls;
        // R1: reset clears outputs even with valid asserted
        in_valid = 1'b1;
        in_exp = 4'd5; in_sig = 4'b1111; in_extra = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 word", int'(out_word), 0);
        check("R1 flags", int'({out_inexact, out_overflow}), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Exhaustive sweep over sign, mode, exponent, significand, extra bits.
        for (int s = 0; s < 2; s++)
        for (int m = 0; m < 4; m++)
        for (int e = 0; e < (1 << EW); e++)
        for (int sg = 0; sg < (1 << (FW + 1)); sg++)
        for (int x = 0; x < (1 << XW); x++) begin
            if (e != 0 && sg < (1 << FW)) continue;
            @(negedge clk);
            in_valid = 1'b1;
            in_sign = s[0]; in_mode = m[1:0]; in_exp = e[EW-1:0];
            in_sig = sg[FW:0]; in_extra = x[XW-1:0];
            @(negedge clk);
            model(s, m, e, sg, x, w, ix, ov, cls);
            check({cls, " word"}, int'(out_word), w);
            check("R10 inexact", int'(out_inexact), ix);
            check("R9 overflow", int'(out_overflow), ov);
            check("R2 valid", int'(out_valid), 1);
            check("R11 sign", int'(out_word[WW-1]), s);
        end

        // R2: idle cycle keeps the last result and drops valid.
        @(negedge clk);
        in_valid = 1'b1; in_sign = 1'b0; in_mode = 2'b00;
        in_exp = 4'd3; in_sig = 4'b1011; in_extra = 3'b100;
        @(negedge clk);
        check("R3 tie to even up", int'(out_word), (3 << FW) | 3'b100);
        in_valid = 1'b0; in_sign = 1'b1; in_exp = 4'd14; in_sig = 4'b1111; in_extra = 3'b111;
        @(negedge clk);
        check("R2 valid low", int'(out_valid), 0);
        check("R2 word held", int'(out_word), (3 << FW) | 3'b100);
        check("R2 flags held", int'({out_inexact, out_overflow}), 2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule